// File: doc/BRIEF.md
# Universal Counter Shift Register

A 4-bit storage stage that acts either as a modulo-16 up/down counter or as a bidirectional shift register. A 3-bit operation code picks one of eight synchronous operations, applied on the rising clock edge: parallel load, bitwise invert, shift in either direction, count down, synchronous clear, count up and hold. An active-high reset input clears the stage asynchronously and overrides every other input.

Two active-low enables gate counting: a local enable and a chain enable. The chain enable also serves as the serial input when shifting toward the top bit. An active-low terminal output flags the end of a count, and in shift modes it carries the top bit instead. Wiring one stage's terminal output to the next stage's chain enable builds wider counters or shift registers with no extra logic.

Top module: `univ_cnt_shift`

## Requirements
- R1: With `mode` = 3'b000 (load), a rising clock edge copies `par_d` into `q`.
- R2: With `mode` = 3'b001 (invert), a rising clock edge replaces every bit of `q` by its complement.
- R3: With `mode` = 3'b010 (shift toward bit 0), a rising clock edge moves each bit of `q` one place toward bit 0, and `hi_ser_in` enters the top bit `q[3]`.
- R4: With `mode` = 3'b011 (shift toward the top bit), a rising clock edge moves each bit of `q` one place toward `q[3]`, and the level on `chain_n` enters `q[0]`.
- R5: With `mode` = 3'b110 (count up) and both `cnt_en_n` and `chain_n` low, a rising clock edge adds one to `q` modulo 16 (4'hF steps to 4'h0).
- R6: With `mode` = 3'b100 (count down) and both enables low, a rising clock edge subtracts one from `q` modulo 16 (4'h0 steps to 4'hF).
- R7: In count-up or count-down mode, if `cnt_en_n` or `chain_n` is high, `q` keeps its value across the edge.
- R8: `mode` = 3'b101 clears `q` to 4'h0 on the edge, and `mode` = 3'b111 (hold) leaves `q` unchanged.
- R9: While `rst` is high, `q` is 4'h0 at once, without waiting for a clock edge, whatever the other inputs are.
- R10: `term_n` is combinational. In count-up mode it is low only when `chain_n` is low and `q` = 4'hF. In count-down mode it is low only when `chain_n` is low and `q` = 4'h0. Otherwise it is high. This also holds while `rst` is high.
- R11: In modes 3'b000 to 3'b011, `term_n` equals `q[3]`. In modes 3'b101 and 3'b111, `term_n` is high.
- R12: Two stages chained (lower `term_n` to upper `chain_n`, upper `cnt_en_n` low, shared `mode`) count up as one 8-bit counter and shift toward the top bit as one 8-bit shift register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all operations act on its rising edge |
| rst | input | 1 | Asynchronous active-high clear of the stage |
| mode | input | 3 | Operation code (see R1 to R8) |
| par_d | input | 4 | Parallel load value |
| cnt_en_n | input | 1 | Active-low local count enable |
| chain_n | input | 1 | Active-low chain count enable; serial input when shifting toward the top bit |
| hi_ser_in | input | 1 | Serial input into the top bit when shifting toward bit 0 |
| q | output | 4 | Register contents |
| term_n | output | 1 | Active-low terminal count, or the top bit in load, invert and shift modes |

## Verification
Every register result is due at the first rising edge after its operation code and operands are presented. The bench drives inputs on the falling edge and samples `q` on the next falling edge, one edge later. `term_n` and the reset clear are due in the same cycle, so they are sampled on the falling edge itself, or 1 ns after `rst` rises, before any clock edge comes. In the chained pair the carry between stages settles within one cycle, so both halves are read together after each single edge.

// File: rtl/ucs_pkg.sv
package ucs_pkg;

    typedef enum logic [2:0] {
        OP_LOAD   = 3'b000,
        OP_INV    = 3'b001,
        OP_SH_LO  = 3'b010,
        OP_SH_HI  = 3'b011,
        OP_DEC    = 3'b100,
        OP_CLR    = 3'b101,
        OP_INC    = 3'b110,
        OP_HOLD   = 3'b111
    } op_e;

    typedef struct packed {
        op_e  op;
        logic loc_en_n;
        logic chn_en_n;
        logic hi_ser;
    } ctl_t;

    function automatic logic step_ok(input logic loc_n, input logic chn_n);
        return (!loc_n) && (!chn_n);
    endfunction

    function automatic logic is_count_op(input op_e op);
        return (op == OP_INC) || (op == OP_DEC);
    endfunction

    function automatic logic follows_msb(input op_e op);
        return (op == OP_LOAD) || (op == OP_INV) ||
               (op == OP_SH_LO) || (op == OP_SH_HI);
    endfunction

endpackage

// File: rtl/ucs_next.sv
module ucs_next
    import ucs_pkg::*;
#(
    parameter int W = 4
) (
    input  ctl_t         ctl,
    input  logic [W-1:0] cur,
    input  logic [W-1:0] par_d,
    output logic [W-1:0] nxt
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] to_lo;
    logic [W-1:0] to_hi;
    logic         go;

    // Shift toward bit 0: the top bit takes the serial input.
    for (genvar i = 0; i < W; i++) begin : g_lo
        if (i == W - 1) begin : g_top
            assign to_lo[i] = ctl.hi_ser;
        end else begin : g_mid
            assign to_lo[i] = cur[i+1];
        end
    end

    // Shift toward the top bit: bit 0 takes the chain input.
    for (genvar i = 0; i < W; i++) begin : g_hi
        if (i == 0) begin : g_bot
            assign to_hi[i] = ctl.chn_en_n;
        end else begin : g_mid
            assign to_hi[i] = cur[i-1];
        end
    end

    assign go = step_ok(ctl.loc_en_n, ctl.chn_en_n);

    always_comb begin
        unique case (ctl.op)
            OP_LOAD:  nxt = par_d;
            OP_INV:   nxt = ~cur;
            OP_SH_LO: nxt = to_lo;
            OP_SH_HI: nxt = to_hi;
            OP_DEC:   nxt = go ? cur - ONE : cur;
            OP_CLR:   nxt = '0;
            OP_INC:   nxt = go ? cur + ONE : cur;
            default:  nxt = cur;
        endcase
    end

endmodule

// File: rtl/ucs_term.sv
module ucs_term
    import ucs_pkg::*;
#(
    parameter int W = 4
) (
    input  ctl_t         ctl,
    input  logic [W-1:0] cur,
    output logic         term_n
);
    logic at_top;
    logic at_bot;

    assign at_top = &cur;
    assign at_bot = ~|cur;

    always_comb begin
        if (follows_msb(ctl.op)) begin
            term_n = cur[W-1];
        end else if (ctl.op == OP_INC) begin
            term_n = !(!ctl.chn_en_n && at_top);
        end else if (ctl.op == OP_DEC) begin
            term_n = !(!ctl.chn_en_n && at_bot);
        end else begin
            term_n = 1'b1;
        end
    end

endmodule

// File: rtl/ucs_store.sv
module ucs_store #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] nxt,
    output logic [W-1:0] cur
);
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            cur <= '0;
        end else begin
            cur <= nxt;
        end
    end

endmodule

// File: rtl/univ_cnt_shift.sv
module univ_cnt_shift
    import ucs_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [2:0]   mode,
    input  logic [W-1:0] par_d,
    input  logic         cnt_en_n,
    input  logic         chain_n,
    input  logic         hi_ser_in,
    output logic [W-1:0] q,
    output logic         term_n
);
    ctl_t         ctl;
    logic [W-1:0] nxt;

    assign ctl.op       = op_e'(mode);
    assign ctl.loc_en_n = cnt_en_n;
    assign ctl.chn_en_n = chain_n;
    assign ctl.hi_ser   = hi_ser_in;

    ucs_next #(.W(W)) u_next (
        .ctl   (ctl),
        .cur   (q),
        .par_d (par_d),
        .nxt   (nxt)
    );

    ucs_store #(.W(W)) u_store (
        .clk (clk),
        .rst (rst),
        .nxt (nxt),
        .cur (q)
    );

    ucs_term #(.W(W)) u_term (
        .ctl    (ctl),
        .cur    (q),
        .term_n (term_n)
    );

endmodule

// File: rtl/ucs_chk.sv
module ucs_chk #(
    parameter int W = 4
) (
    input logic         clk,
    input logic         rst,
    input logic [2:0]   mode,
    input logic [W-1:0] par_d,
    input logic         cnt_en_n,
    input logic         chain_n,
    input logic         hi_ser_in,
    input logic [W-1:0] q,
    input logic         term_n
);
    a_r1_load: assert property (@(posedge clk) disable iff (rst)
        mode == 3'b000 |=> q == $past(par_d));

    a_r2_invert: assert property (@(posedge clk) disable iff (rst)
        mode == 3'b001 |=> q == ~$past(q));

    a_r3_shift_lo: assert property (@(posedge clk) disable iff (rst)
        mode == 3'b010 |=> q == {$past(hi_ser_in), $past(q[W-1:1])});

    a_r4_shift_hi: assert property (@(posedge clk) disable iff (rst)
        mode == 3'b011 |=> q == {$past(q[W-2:0]), $past(chain_n)});

    a_r5_count_up: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'b110 && !cnt_en_n && !chain_n) |=> q == $past(q) + W'(1));

    a_r6_count_down: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'b100 && !cnt_en_n && !chain_n) |=> q == $past(q) - W'(1));

    a_r7_count_gated: assert property (@(posedge clk) disable iff (rst)
        ((mode == 3'b110 || mode == 3'b100) && (cnt_en_n || chain_n)) |=> $stable(q));

    a_r8_clear: assert property (@(posedge clk) disable iff (rst)
        mode == 3'b101 |=> q == '0);

    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        mode == 3'b111 |=> $stable(q));

    a_r9_reset_clear: assert property (@(posedge clk)
        ($past(rst) && rst) |-> q == '0);

    a_r10_term_up_low: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'b110 && !chain_n && (&q)) |-> !term_n);

    a_r10_term_dn_low: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'b100 && !chain_n && !(|q)) |-> !term_n);

    a_r10_term_cnt_high: assert property (@(posedge clk) disable iff (rst)
        ((mode == 3'b110 || mode == 3'b100) && chain_n) |-> term_n);

    a_r11_term_msb: assert property (@(posedge clk) disable iff (rst)
        (mode[2] == 1'b0) |-> term_n == q[W-1]);

    a_r11_term_idle: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'b101 || mode == 3'b111) |-> term_n);

endmodule

bind univ_cnt_shift ucs_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mode      (mode),
    .par_d     (par_d),
    .cnt_en_n  (cnt_en_n),
    .chain_n   (chain_n),
    .hi_ser_in (hi_ser_in),
    .q         (q),
    .term_n    (term_n)
);

// File: tb/univ_cnt_shift_test.sv
module univ_cnt_shift_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] mode = 3'b111;
    logic [3:0] par_lo = 4'h0;
    logic [3:0] par_hi = 4'h0;
    logic       en_n = 1'b1;
    logic       ch0 = 1'b1;
    logic       hs0 = 1'b0;
    logic [3:0] q_lo;
    logic [3:0] q_hi;
    logic       tn_lo;
    logic       tn_hi;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    univ_cnt_shift #(.W(4)) uut (
        .clk(clk), .rst(rst), .mode(mode), .par_d(par_lo),
        .cnt_en_n(en_n), .chain_n(ch0), .hi_ser_in(hs0),
        .q(q_lo), .term_n(tn_lo)
    );

    univ_cnt_shift #(.W(4)) uut_hi (
        .clk(clk), .rst(rst), .mode(mode), .par_d(par_hi),
        .cnt_en_n(1'b0), .chain_n(tn_lo), .hi_ser_in(1'b0),
        .q(q_hi), .term_n(tn_hi)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic load(input logic [3:0] v);
        mode = 3'b000; par_lo = v;
        tick();
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R9 reset q", q_lo, 0);
        chk("R11 term in hold", tn_lo, 1);
        rst = 1'b0;
        load(4'hA);
        chk("R1 load", q_lo, 4'hA);
        chk("R11 term follows msb", tn_lo, 1);
        mode = 3'b000; par_lo = 4'hF;
        #0.5 rst = 1'b1;
        #0.5;
        chk("R9 async clear before edge", q_lo, 0);
        tick();
        chk("R9 overrides load", q_lo, 0);
        mode = 3'b110; ch0 = 1'b0;
        #0.5;
        chk("R10 term up during reset", tn_lo, 1);
        mode = 3'b100;
        #0.5;
        chk("R10 term down during reset", tn_lo, 0);
        @(negedge clk);
        rst = 1'b0; ch0 = 1'b1; mode = 3'b111;
    endtask

    task automatic t_invert();
        load(4'hA);
        mode = 3'b001;
        tick();
        chk("R2 invert", q_lo, 4'h5);
        chk("R11 term msb after invert", tn_lo, 0);
    endtask

    task automatic t_shift();
        load(4'h6);
        mode = 3'b010; hs0 = 1'b1;
        tick();
        chk("R3 shift lo in 1", q_lo, 4'hB);
        chk("R11 term msb in shift", tn_lo, 1);
        hs0 = 1'b0;
        tick();
        chk("R3 shift lo in 0", q_lo, 4'h5);
        load(4'h6);
        mode = 3'b011; ch0 = 1'b1;
        tick();
        chk("R4 shift hi in 1", q_lo, 4'hD);
        ch0 = 1'b0;
        tick();
        chk("R4 shift hi in 0", q_lo, 4'hA);
        ch0 = 1'b1;
    endtask

    task automatic t_count();
        load(4'hD);
        mode = 3'b110; en_n = 1'b0; ch0 = 1'b0;
        tick();
        chk("R5 up", q_lo, 4'hE);
        chk("R10 term up not top", tn_lo, 1);
        tick();
        chk("R5 up to top", q_lo, 4'hF);
        chk("R10 term up at top", tn_lo, 0);
        ch0 = 1'b1;
        #0.5;
        chk("R10 term up chain high", tn_lo, 1);
        tick();
        chk("R7 chain high holds", q_lo, 4'hF);
        ch0 = 1'b0; en_n = 1'b1;
        tick();
        chk("R7 local high holds", q_lo, 4'hF);
        en_n = 1'b0;
        tick();
        chk("R5 wrap to zero", q_lo, 4'h0);
        load(4'h1);
        mode = 3'b100; ch0 = 1'b0; en_n = 1'b0;
        tick();
        chk("R6 down", q_lo, 4'h0);
        chk("R10 term down at zero", tn_lo, 0);
        tick();
        chk("R6 wrap to F", q_lo, 4'hF);
        chk("R10 term down not zero", tn_lo, 1);
        en_n = 1'b1;
        tick();
        chk("R7 down gated", q_lo, 4'hF);
        ch0 = 1'b1;
    endtask

    task automatic t_clear_hold();
        load(4'h9);
        mode = 3'b111;
        tick();
        chk("R8 hold", q_lo, 4'h9);
        chk("R11 term high in hold", tn_lo, 1);
        mode = 3'b101;
        #0.5;
        chk("R11 term high in clear", tn_lo, 1);
        tick();
        chk("R8 sync clear", q_lo, 4'h0);
    endtask

    task automatic t_chain();
        mode = 3'b000; par_lo = 4'hE; par_hi = 4'h3;
        tick();
        chk("R12 chain load", {q_hi, q_lo}, 8'h3E);
        mode = 3'b110; en_n = 1'b0; ch0 = 1'b0;
        tick();
        chk("R12 chain count 3F", {q_hi, q_lo}, 8'h3F);
        tick();
        chk("R12 chain carry 40", {q_hi, q_lo}, 8'h40);
        tick();
        chk("R12 chain count 41", {q_hi, q_lo}, 8'h41);
        mode = 3'b000; par_lo = 4'h9; par_hi = 4'h2;
        tick();
        mode = 3'b011; ch0 = 1'b1;
        tick();
        chk("R12 chain shift 53", {q_hi, q_lo}, 8'h53);
        ch0 = 1'b0;
        tick();
        chk("R12 chain shift A6", {q_hi, q_lo}, 8'hA6);
        chk("R11 upper term msb", tn_hi, 1);
        mode = 3'b111; ch0 = 1'b1; en_n = 1'b1;
    endtask

    initial begin
        t_reset();
        t_invert();
        t_shift();
        t_count();
        t_clear_hold();
        t_chain();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule